// File: doc/BRIEF.md
# Coprocessor Instruction Class Dispatcher

This block sits at the front of a floating-point coprocessor path. It takes the first two words of a candidate coprocessor instruction and decides which execution family should handle it. It also takes a third word when the instruction has one, a fault flag for each word, and the current program counter. Each request is answered one clock later. The answer carries a class code and an error code. For branch-class instructions it also carries the sign-extended branch displacement, the instruction length in bytes, and the next program counter.

The opcode word must sit in coprocessor opcode space and carry the expected coprocessor identifier before its 3-bit type field is decoded. General-type instructions are split into register move-multiple and arithmetic by the top bit of the second word. Conditional-type instructions are split by their mode and register fields. Branches come in a short form with a 16-bit displacement and a long form with a 32-bit displacement. Arithmetic execution and condition evaluation are done downstream.

A word-read fault is reported as a memory fault. Decoding stops at the first failure, in the order the words would be fetched. The program counter advances only when no error was found.

Top module: `coproc_dispatch`

## Requirements
- R1: A request with `opFault` set returns error code 2 (memory fault), whatever the opcode word holds.
- R2: If opcode bits 15:12 are not 0xF, the result is error code 1 (illegal).
- R3: If opcode bits 11:9 differ from the coprocessor identifier (default 1), the result is error code 1.
- R4: For opcode type field (bits 8:6) equal to 0, second-word bit 15 set gives class 1 (move-multiple). Bit 15 clear gives class 0 (arithmetic). The length is 4 in both cases.
- R5: For type 1, the class is set by opcode bits 5:3 and 2:0. Bits 5:3 = 1 gives class 2 (decrement-and-branch). Bits 5:3 = 7 with bits 2:0 greater than 1 gives class 4 (trap-on-condition). Every other combination gives class 3 (set-on-condition). The length is 4.
- R6: Type 2 gives class 5 (short branch), a length of 4, and a displacement equal to the second word sign-extended from bit 15 to 32 bits.
- R7: Type 3 gives class 6 (long branch), a length of 6, and a displacement whose upper 16 bits are the second word and lower 16 bits are the third word.
- R8: Types 4 to 7 give error code 1.
- R9: `secFault` gives error code 2 once the opcode word has passed R1 to R3. It takes precedence over R8. `thirdFault` gives error code 2 only for type 3, and it is ignored for every other type.
- R10: On any error, the class is 7 (rejected), the length and displacement are 0, and `pcNext` equals the request's `pcIn`. On success, `pcNext` = `pcIn` + length, modulo 2^32.
- R11: `respValid` is asserted exactly one cycle after `reqValid`. Outputs hold their values through cycles without a request. After reset, `respValid` is 0, the class is 7, and the error code, length, displacement and `pcNext` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| opWord | input | 16 | Opcode word |
| opFault | input | 1 | Fault while reading the opcode word |
| secWord | input | 16 | Second instruction word |
| secFault | input | 1 | Fault while reading the second word |
| thirdWord | input | 16 | Third instruction word (long branch only) |
| thirdFault | input | 1 | Fault while reading the third word |
| pcIn | input | 32 | Program counter of the instruction |
| respValid | output | 1 | Result strobe |
| classCode | output | 3 | Instruction class |
| errCode | output | 2 | 0 success, 1 illegal, 2 memory fault |
| displacement | output | 32 | Branch displacement |
| instLen | output | 4 | Instruction length in bytes |
| pcNext | output | 32 | Program counter after dispatch |

## Verification
The bench probes the error priority with words that are faulty and malformed at the same time. It sends a faulted opcode with a bad nibble, a faulted second word under a bad identifier, and a faulted second word under a reserved type. A design with the checks out of order would return the wrong error code on these. The edge of the conditional-family split (register field 1 against 2 under mode 7) catches an off-by-one comparison. A short branch with a faulted third word catches a design that consults the third word too widely. A negative short displacement catches zero-extension. A long branch with distinct halves catches swapped halves. A program counter near the top of its range catches a wrong advance width, and a request that fails must leave the counter unchanged.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int WORD_W = 16;
  localparam int DISP_W = 2 * WORD_W;

  typedef enum logic [2:0] {
    CLS_GENERAL = 3'd0,
    CLS_MOVEM   = 3'd1,
    CLS_DECBR   = 3'd2,
    CLS_SETCC   = 3'd3,
    CLS_TRAPCC  = 3'd4,
    CLS_BRSHORT = 3'd5,
    CLS_BRLONG  = 3'd6,
    CLS_REJECT  = 3'd7
  } insnClass_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ILLEGAL = 2'd1,
    ERR_FAULT   = 2'd2
  } errCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic advance;   // decode succeeded, length applies
    logic isBranch;  // displacement is meaningful
    logic useThird;  // long form: third word forms the low half
  } dpStrobe_t;
endpackage

// File: rtl/cpd_ctrl.sv
module cpd_ctrl
  import cpd_pkg::*;
#(
  parameter int COP_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WORD_W-1:0] opWord,
  input  logic              opFault,
  input  logic [WORD_W-1:0] secWord,
  input  logic              secFault,
  input  logic              thirdFault,
  output dpStrobe_t         strobe,
  output logic              respValid,
  output insnClass_e        classOut,
  output errCode_e          errOut
);
  localparam int TOP_LSB  = WORD_W - 4;
  localparam int ID_LSB   = 9;
  localparam int TYPE_LSB = 6;
  localparam int MODE_LSB = 3;

  logic [3:0] topNib;
  logic [2:0] idField, typeField, modeField, regField;
  insnClass_e clsNext;
  errCode_e   errNext;
  logic       branchNext, thirdNext;

  assign topNib    = opWord[WORD_W-1:TOP_LSB];
  assign idField   = opWord[ID_LSB+2:ID_LSB];
  assign typeField = opWord[TYPE_LSB+2:TYPE_LSB];
  assign modeField = opWord[MODE_LSB+2:MODE_LSB];
  assign regField  = opWord[2:0];

  always_comb begin
    clsNext    = CLS_REJECT;
    errNext    = ERR_NONE;
    branchNext = 1'b0;
    thirdNext  = 1'b0;
    if (opFault) begin
      errNext = ERR_FAULT;
    end else if (topNib != 4'hF || idField != 3'(COP_ID)) begin
      errNext = ERR_ILLEGAL;
    end else if (secFault) begin
      errNext = ERR_FAULT;
    end else begin
      unique case (typeField)
        3'd0: clsNext = secWord[WORD_W-1] ? CLS_MOVEM : CLS_GENERAL;
        3'd1: begin
          if (modeField == 3'd1)
            clsNext = CLS_DECBR;
          else if (modeField == 3'd7 && regField > 3'd1)
            clsNext = CLS_TRAPCC;
          else
            clsNext = CLS_SETCC;
        end
        3'd2: begin
          clsNext    = CLS_BRSHORT;
          branchNext = 1'b1;
        end
        3'd3: begin
          if (thirdFault) begin
            errNext = ERR_FAULT;
          end else begin
            clsNext    = CLS_BRLONG;
            branchNext = 1'b1;
            thirdNext  = 1'b1;
          end
        end
        default: errNext = ERR_ILLEGAL;
      endcase
    end
  end

  always_comb begin
    strobe.load     = reqValid;
    strobe.advance  = (errNext == ERR_NONE);
    strobe.isBranch = branchNext;
    strobe.useThird = thirdNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      classOut  <= CLS_REJECT;
      errOut    <= ERR_NONE;
    end else begin
      respValid <= reqValid;
      if (reqValid) begin
        classOut <= clsNext;
        errOut   <= errNext;
      end
    end
  end
endmodule

// File: rtl/cpd_datapath.sv
module cpd_datapath
  import cpd_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] secWord,
  input  logic [WORD_W-1:0] thirdWord,
  input  logic [PC_W-1:0]   pcIn,
  output logic [DISP_W-1:0] displacement,
  output logic [LEN_W-1:0]  instLen,
  output logic [PC_W-1:0]   pcNext
);
  localparam int BASE_LEN  = 2 * (WORD_W / 8);
  localparam int EXTRA_LEN = WORD_W / 8;

  logic [DISP_W-1:0] dispCalc;
  logic [LEN_W-1:0]  lenCalc;
  logic [PC_W-1:0]   pcCalc;

  always_comb begin
    if (!strobe.advance || !strobe.isBranch)
      dispCalc = '0;
    else if (strobe.useThird)
      dispCalc = {secWord, thirdWord};
    else
      dispCalc = {{(DISP_W-WORD_W){secWord[WORD_W-1]}}, secWord};
  end

  always_comb begin
    if (!strobe.advance)
      lenCalc = '0;
    else if (strobe.useThird)
      lenCalc = LEN_W'(BASE_LEN + EXTRA_LEN);
    else
      lenCalc = LEN_W'(BASE_LEN);
  end

  assign pcCalc = pcIn + PC_W'(lenCalc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      displacement <= '0;
      instLen      <= '0;
      pcNext       <= '0;
    end else if (strobe.load) begin
      displacement <= dispCalc;
      instLen      <= lenCalc;
      pcNext       <= pcCalc;
    end
  end
endmodule

// File: rtl/coproc_dispatch.sv
module coproc_dispatch
  import cpd_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int LEN_W  = 4,
  parameter int COP_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [15:0]       opWord,
  input  logic              opFault,
  input  logic [15:0]       secWord,
  input  logic              secFault,
  input  logic [15:0]       thirdWord,
  input  logic              thirdFault,
  input  logic [PC_W-1:0]   pcIn,
  output logic              respValid,
  output logic [2:0]        classCode,
  output logic [1:0]        errCode,
  output logic [31:0]       displacement,
  output logic [LEN_W-1:0]  instLen,
  output logic [PC_W-1:0]   pcNext
);
  dpStrobe_t  strobe;
  insnClass_e classQ;
  errCode_e   errQ;

  cpd_ctrl #(.COP_ID(COP_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .opWord(opWord), .opFault(opFault),
    .secWord(secWord), .secFault(secFault), .thirdFault(thirdFault),
    .strobe(strobe), .respValid(respValid),
    .classOut(classQ), .errOut(errQ)
  );

  cpd_datapath #(.PC_W(PC_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .secWord(secWord), .thirdWord(thirdWord), .pcIn(pcIn),
    .displacement(displacement), .instLen(instLen), .pcNext(pcNext)
  );

  assign classCode = classQ;
  assign errCode   = errQ;
endmodule

// File: rtl/coproc_dispatch_chk.sv
module coproc_dispatch_chk #(
  parameter int PC_W  = 32,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             opFault,
  input logic [PC_W-1:0]  pcIn,
  input logic             respValid,
  input logic [2:0]       classCode,
  input logic [1:0]       errCode,
  input logic [31:0]      displacement,
  input logic [LEN_W-1:0] instLen,
  input logic [PC_W-1:0]  pcNext
);
  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  assert_opfault_is_fault_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opFault) |=> errCode == 2'd2);
  assert_error_holds_pc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opFault) ##1 (respValid && errCode != 2'd0)
      |-> (pcNext == $past(pcIn) && instLen == '0 && displacement == '0 && classCode == 3'd7));
  assert_success_advance_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid ##1 (respValid && errCode == 2'd0)
      |-> pcNext == $past(pcIn) + PC_W'(instLen));
  assert_long_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && classCode == 3'd6) |-> instLen == LEN_W'(6));
  assert_error_code_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 2'd3);
endmodule

bind coproc_dispatch coproc_dispatch_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .opFault(opFault), .pcIn(pcIn),
  .respValid(respValid), .classCode(classCode), .errCode(errCode),
  .displacement(displacement), .instLen(instLen), .pcNext(pcNext)
);

// File: tb/tb_coproc_dispatch.sv
module tb_coproc_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] opWord = '0, secWord = '0, thirdWord = '0;
  logic        opFault = 1'b0, secFault = 1'b0, thirdFault = 1'b0;
  logic [31:0] pcIn = '0;
  logic        respValid;
  logic [2:0]  classCode;
  logic [1:0]  errCode;
  logic [31:0] displacement;
  logic [3:0]  instLen;
  logic [31:0] pcNext;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  cls;
    logic [1:0]  err;
    logic [31:0] disp;
    logic [3:0]  len;
    logic [31:0] pc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  coproc_dispatch dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .opWord(opWord), .opFault(opFault), .secWord(secWord), .secFault(secFault),
    .thirdWord(thirdWord), .thirdFault(thirdFault), .pcIn(pcIn),
    .respValid(respValid), .classCode(classCode), .errCode(errCode),
    .displacement(displacement), .instLen(instLen), .pcNext(pcNext)
  );

  // reference model written from the requirements
  function automatic exp_t model(logic [15:0] op, bit of, logic [15:0] w1, bit sf,
                                 logic [15:0] w2, bit tf, logic [31:0] pc, string tag);
    exp_t e;
    e.cls = 3'd7; e.err = 2'd0; e.disp = '0; e.len = '0; e.tag = tag;
    if (of) e.err = 2'd2;                                   // R1
    else if (op[15:12] != 4'hF || op[11:9] != 3'd1) e.err = 2'd1; // R2 R3
    else if (sf) e.err = 2'd2;                              // R9
    else begin
      case (op[8:6])
        3'd0: begin e.cls = w1[15] ? 3'd1 : 3'd0; e.len = 4; end // R4
        3'd1: begin                                          // R5
          e.len = 4;
          if (op[5:3] == 3'd1) e.cls = 3'd2;
          else if (op[5:3] == 3'd7 && op[2:0] > 3'd1) e.cls = 3'd4;
          else e.cls = 3'd3;
        end
        3'd2: begin e.cls = 3'd5; e.len = 4; e.disp = {{16{w1[15]}}, w1}; end // R6
        3'd3: begin
          if (tf) e.err = 2'd2;
          else begin e.cls = 3'd6; e.len = 6; e.disp = {w1, w2}; end // R7
        end
        default: e.err = 2'd1;                               // R8
      endcase
    end
    e.pc = (e.err == 2'd0) ? pc + 32'(e.len) : pc;           // R10
    return e;
  endfunction

  task automatic send(logic [15:0] op, bit of, logic [15:0] w1, bit sf,
                      logic [15:0] w2, bit tf, logic [31:0] pc, string tag);
    opWord = op; opFault = of; secWord = w1; secFault = sf;
    thirdWord = w2; thirdFault = tf; pcIn = pc; reqValid = 1'b1;
    sb.push_back(model(op, of, w1, sf, w2, tf, pc, tag));
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected response", 64'(respValid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(classCode == e.cls && errCode == e.err && displacement == e.disp &&
              instLen == e.len && pcNext == e.pc, e.tag, "cls/err/disp/len/pc",
              {classCode, errCode, instLen, displacement, pcNext[22:0]},
              {e.cls, e.err, e.len, e.disp, e.pc[22:0]});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  hc;
    logic [31:0] hp, hd;
    repeat (3) @(negedge clk);
    check(respValid == 0 && classCode == 3'd7 && errCode == 0 && instLen == 0 &&
          displacement == 0 && pcNext == 0, "R11", "reset state",
          {respValid, classCode, errCode, instLen}, {1'b0, 3'd7, 2'd0, 4'd0});
    rstN = 1'b1;
    @(negedge clk);

    send(16'hF200, 0, 16'h0022, 0, 0, 0, 32'h1000, "R4 arith");
    send(16'hF210, 0, 16'hE0FF, 0, 0, 0, 32'h1004, "R4 movem");
    send(16'hF248, 0, 16'h0001, 0, 0, 0, 32'h2000, "R5 decbr");
    send(16'hF27A, 0, 16'h0000, 0, 0, 0, 32'h2004, "R5 trap reg2");
    send(16'hF279, 0, 16'h0000, 0, 0, 0, 32'h2008, "R5 setcc reg1");
    send(16'hF250, 0, 16'h0000, 0, 0, 0, 32'h200C, "R5 setcc mode2");
    send(16'hF280, 0, 16'h8004, 0, 0, 0, 32'h3000, "R6 negative");
    send(16'hF280, 0, 16'h0010, 0, 0, 0, 32'h3010, "R6 positive");
    send(16'hF2C0, 0, 16'h1234, 0, 16'hABCD, 0, 32'h4000, "R7 long");
    send(16'hF2C0, 0, 16'h1234, 0, 16'hABCD, 1, 32'h4100, "R9 third fault");
    send(16'hF280, 0, 16'h0008, 0, 16'hFFFF, 1, 32'h4200, "R9 third ignored");
    send(16'hF300, 0, 16'h0000, 0, 0, 0, 32'h5000, "R8 type4");
    send(16'hF3C0, 0, 16'h0000, 0, 0, 0, 32'h5004, "R8 type7");
    send(16'hE200, 0, 16'h0000, 0, 0, 0, 32'h6000, "R2 nibble");
    send(16'hF400, 0, 16'h0000, 0, 0, 0, 32'h6004, "R3 id2");
    send(16'hF000, 0, 16'h0000, 0, 0, 0, 32'h6008, "R3 id0");
    send(16'hF200, 1, 16'h0000, 0, 0, 0, 32'h7000, "R1 legal op");
    send(16'h1200, 1, 16'h0000, 1, 0, 0, 32'h7004, "R1 over nibble");
    send(16'hF200, 0, 16'h0000, 1, 0, 0, 32'h7008, "R9 sec fault");
    send(16'hF600, 0, 16'h0000, 1, 0, 0, 32'h700C, "R9 id first");
    send(16'hF340, 0, 16'h0000, 1, 0, 0, 32'h7010, "R9 over type");
    send(16'hF2C0, 0, 16'hFFFF, 0, 16'h0002, 0, 32'hFFFF_FFFE, "R10 wrap");
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R11", "responses drained", 64'(sb.size()), 64'd0);

    // hold: inputs change without a request
    hc = classCode; hp = pcNext; hd = displacement;
    opWord = 16'hF280; secWord = 16'h7777; pcIn = 32'h9999_0000;
    repeat (2) @(negedge clk);
    check(classCode == hc && pcNext == hp && displacement == hd && !respValid,
          "R11", "hold without request", {classCode, pcNext}, {hc, hp});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule